// File: doc/BRIEF.md
# UART Receive Status and Interrupt Unit

This unit sits directly behind a UART receive shifter. When the shifter finishes a character, it gives this unit a one-cycle strobe. The strobe comes with the data byte, the received parity bit, an address-mark bit and a framing-error indication. The unit decides whether the character enters the receive buffer and whether it raises the receive interrupt flag. It keeps sticky status flags for overrun, parity error, wake-up (address character seen) and line break. Software clears these flags by reading the buffer or by pulsing a soft reset.

Two enables shape the acceptance rule:

- **Error enable:** when low, characters with a parity or framing error are dropped.
- **Wake enable:** when high, only characters carrying the address mark are kept.

A character is written into the buffer exactly when it would raise the interrupt flag, so the buffer always holds the character that caused the last interrupt.

A separate break detector watches the raw RX level on each bit-time tick. It arms when a character arrives with a missing stop bit. It reports a break after a set number of low bit times, at most once per low period.

Top module: `uart_rx_status`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the buffer is zero and all flags (interrupt, break, overrun, parity error, wake) are low.
- R2: The unit treats a character as erroneous when it has a framing error or a parity mismatch. With error enable low, an erroneous character is discarded: buffer and interrupt flag keep their values.
- R3: With error enable low and wake enable low, an error-free character is written to the buffer. It sets the interrupt flag in the cycle after its strobe.
- R4: With wake enable high, a character without the address mark is discarded. A character with the mark is loaded and sets the interrupt flag, subject to R2.
- R5: With error enable high and wake enable low, every character is loaded and sets the interrupt flag, erroneous or not.
- R6: The parity error flag sets when a loaded character fails its parity check. The check is the XOR of the data bits, the address bit and the parity bit. Under even polarity (`parity_odd_i` = 0) a correct character gives 0; under odd polarity (`parity_odd_i` = 1) it gives 1. The flag is sticky until it is cleared.
- R7: The wake flag sets when a loaded character carries the address mark.
- R8: Loading a character while the previous one is still unread overwrites the buffer and sets the overrun flag.
- R9: A buffer-read strobe clears the interrupt, break, overrun, parity and wake flags; the buffer keeps its data. If a character loads in the same cycle, its effects win.
- R10: A soft-reset strobe clears the buffer, all flags and the break detector.
- R11: After a framing-error strobe arms the detector, BRK_BITS (10) further bit ticks that sample the line low signal a break. A tick that samples the line high restarts detection. The break is flagged, and sets the interrupt flag, only while error enable is high.
- R12: A break is signalled at most once per low period, and later characters do not clear the break flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| char_valid_i | input | 1 | One-cycle strobe: a character is complete |
| char_data_i | input | DATA_W | Received data byte |
| char_parity_i | input | 1 | Received parity bit |
| char_addr_i | input | 1 | Address-mark bit of the character |
| frame_err_i | input | 1 | Stop bit was missing |
| rx_line_i | input | 1 | Raw receive line level |
| bit_tick_i | input | 1 | One pulse per bit time |
| buf_read_i | input | 1 | Receive buffer is being read |
| soft_rst_i | input | 1 | Synchronous soft reset |
| err_ie_i | input | 1 | Error enable |
| wake_ie_i | input | 1 | Wake enable (address characters only) |
| parity_odd_i | input | 1 | Parity polarity: 0 even, 1 odd |
| buf_data_o | output | DATA_W | Receive buffer contents |
| irq_flag_o | output | 1 | Receive interrupt flag |
| break_o | output | 1 | Break flag |
| overrun_o | output | 1 | Overrun flag |
| parity_err_o | output | 1 | Parity error flag |
| wake_o | output | 1 | Wake (address character) flag |

## Verification
Characters are sent under all four combinations of the two enables, each with and without errors and address marks:

- **Acceptance:** a dropped character shows up as an unchanged buffer, so these cases separate "discarded" from "loaded but flag unchanged".
- **Parity:** the same byte is sent under both polarities, which separates a wrong polarity from a missing address bit in the parity check.
- **Overrun and same-cycle read:** back-to-back unread loads, and a read coinciding with a load, settle the priority between read and load.

Break stimulus uses long low periods:

- **Restart:** a high tick mid-count must restart detection.
- **Count boundary:** the break must appear on the tenth low tick and not on the ninth.
- **Break with error enable low:** no break flag may appear.
- **Once per low period:** a read during a continued low period must not let the break return.

// File: rtl/uart_rx_status_pkg.sv
package uart_rx_status_pkg;

  typedef struct packed {
    logic load;
    logic par_bad;
    logic addr;
  } rx_decision_t;

  typedef struct packed {
    logic irq;
    logic brk;
    logic ovr;
    logic perr;
    logic wake;
  } rx_flags_t;

  localparam rx_flags_t FLAGS_CLEAR = '{irq: 1'b0, brk: 1'b0, ovr: 1'b0, perr: 1'b0, wake: 1'b0};

endpackage

// File: rtl/uart_rx_accept.sv
module uart_rx_accept
  import uart_rx_status_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              char_valid_i,
  input  logic [DATA_W-1:0] char_data_i,
  input  logic              char_parity_i,
  input  logic              char_addr_i,
  input  logic              frame_err_i,
  input  logic              err_ie_i,
  input  logic              wake_ie_i,
  input  logic              parity_odd_i,
  output rx_decision_t      dec_o
);

  logic ones_odd;
  logic par_bad;
  logic char_err;
  logic pass_err;
  logic pass_wake;

  // address bit is part of the parity word
  assign ones_odd  = ^{char_data_i, char_addr_i, char_parity_i};
  assign par_bad   = ones_odd ^ parity_odd_i;
  assign char_err  = par_bad | frame_err_i;
  assign pass_err  = ~char_err | err_ie_i;
  assign pass_wake = ~wake_ie_i | char_addr_i;

  always_comb begin
    dec_o.load    = char_valid_i & pass_err & pass_wake;
    dec_o.par_bad = par_bad;
    dec_o.addr    = char_addr_i;
  end

endmodule

// File: rtl/uart_rx_break_det.sv
module uart_rx_break_det #(
  parameter int BRK_BITS = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic soft_rst_i,
  input  logic char_valid_i,
  input  logic frame_err_i,
  input  logic rx_line_i,
  input  logic bit_tick_i,
  output logic brk_evt_o
);

  localparam int CNT_W = $clog2(BRK_BITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BRK_BITS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic             fired_q;
  logic             tick_high;
  logic             tick_low;
  logic             arm;

  assign tick_high = bit_tick_i & rx_line_i;
  assign tick_low  = bit_tick_i & ~rx_line_i;
  assign brk_evt_o = tick_low & armed_q & (cnt_q == LAST);
  // arm once per low period, on the first missing stop bit
  assign arm       = char_valid_i & frame_err_i & ~armed_q & ~fired_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      fired_q <= 1'b0;
    end else if (soft_rst_i || tick_high) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      fired_q <= 1'b0;
    end else if (brk_evt_o) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      fired_q <= 1'b1;
    end else if (tick_low && armed_q) begin
      cnt_q   <= cnt_q + 1'b1;
    end else if (arm) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end
  end

endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags
  import uart_rx_status_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              buf_read_i,
  input  rx_decision_t      dec_i,
  input  logic [DATA_W-1:0] char_data_i,
  input  logic              brk_evt_i,
  input  logic              err_ie_i,
  output logic [DATA_W-1:0] buf_o,
  output rx_flags_t         flags_o
);

  logic [DATA_W-1:0] buf_q;
  logic              full_q;
  rx_flags_t         flags_q;
  rx_flags_t         flags_d;
  logic              full_d;
  logic              brk_set;

  assign brk_set = brk_evt_i & err_ie_i;

  always_comb begin
    flags_d = flags_q;
    full_d  = full_q;
    if (buf_read_i) begin
      flags_d = FLAGS_CLEAR;
      full_d  = 1'b0;
    end
    if (dec_i.load) begin
      full_d      = 1'b1;
      flags_d.irq = 1'b1;
      if (full_q && !buf_read_i) flags_d.ovr = 1'b1;
      if (dec_i.par_bad) flags_d.perr = 1'b1;
      if (dec_i.addr) flags_d.wake = 1'b1;
    end
    if (brk_set) begin
      flags_d.brk = 1'b1;
      flags_d.irq = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q   <= '0;
      full_q  <= 1'b0;
      flags_q <= FLAGS_CLEAR;
    end else if (soft_rst_i) begin
      buf_q   <= '0;
      full_q  <= 1'b0;
      flags_q <= FLAGS_CLEAR;
    end else begin
      if (dec_i.load) buf_q <= char_data_i;
      full_q  <= full_d;
      flags_q <= flags_d;
    end
  end

  assign buf_o   = buf_q;
  assign flags_o = flags_q;

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_status_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int BRK_BITS = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              char_valid_i,
  input  logic [DATA_W-1:0] char_data_i,
  input  logic              char_parity_i,
  input  logic              char_addr_i,
  input  logic              frame_err_i,
  input  logic              rx_line_i,
  input  logic              bit_tick_i,
  input  logic              buf_read_i,
  input  logic              soft_rst_i,
  input  logic              err_ie_i,
  input  logic              wake_ie_i,
  input  logic              parity_odd_i,
  output logic [DATA_W-1:0] buf_data_o,
  output logic              irq_flag_o,
  output logic              break_o,
  output logic              overrun_o,
  output logic              parity_err_o,
  output logic              wake_o
);

  rx_decision_t dec;
  rx_flags_t    flags;
  logic         brk_evt;

  uart_rx_accept #(.DATA_W(DATA_W)) i_accept (
    .char_valid_i (char_valid_i),
    .char_data_i  (char_data_i),
    .char_parity_i(char_parity_i),
    .char_addr_i  (char_addr_i),
    .frame_err_i  (frame_err_i),
    .err_ie_i     (err_ie_i),
    .wake_ie_i    (wake_ie_i),
    .parity_odd_i (parity_odd_i),
    .dec_o        (dec)
  );

  uart_rx_break_det #(.BRK_BITS(BRK_BITS)) i_break (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .soft_rst_i  (soft_rst_i),
    .char_valid_i(char_valid_i),
    .frame_err_i (frame_err_i),
    .rx_line_i   (rx_line_i),
    .bit_tick_i  (bit_tick_i),
    .brk_evt_o   (brk_evt)
  );

  uart_rx_flags #(.DATA_W(DATA_W)) i_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst_i),
    .buf_read_i (buf_read_i),
    .dec_i      (dec),
    .char_data_i(char_data_i),
    .brk_evt_i  (brk_evt),
    .err_ie_i   (err_ie_i),
    .buf_o      (buf_data_o),
    .flags_o    (flags)
  );

  assign irq_flag_o   = flags.irq;
  assign break_o      = flags.brk;
  assign overrun_o    = flags.ovr;
  assign parity_err_o = flags.perr;
  assign wake_o       = flags.wake;

endmodule

// File: rtl/uart_rx_status_chk.sv
module uart_rx_status_chk #(
  parameter int DATA_W   = 8,
  parameter int BRK_BITS = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              char_valid_i,
  input logic [DATA_W-1:0] char_data_i,
  input logic              char_parity_i,
  input logic              char_addr_i,
  input logic              frame_err_i,
  input logic              rx_line_i,
  input logic              bit_tick_i,
  input logic              buf_read_i,
  input logic              soft_rst_i,
  input logic              err_ie_i,
  input logic              wake_ie_i,
  input logic              parity_odd_i,
  input logic [DATA_W-1:0] buf_data_o,
  input logic              irq_flag_o,
  input logic              break_o,
  input logic              overrun_o,
  input logic              parity_err_o,
  input logic              wake_o
);

  p_reset_clear_r1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (buf_data_o == '0) && !irq_flag_o && !break_o && !overrun_o
                      && !parity_err_o && !wake_o);

  p_frame_drop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_valid_i && frame_err_i && !err_ie_i && !soft_rst_i && !buf_read_i
    |=> $stable(buf_data_o) && $stable(irq_flag_o));

  p_wake_filter_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_valid_i && wake_ie_i && !char_addr_i && !soft_rst_i && !buf_read_i && !bit_tick_i
    |=> $stable(buf_data_o) && $stable(irq_flag_o));

  p_accept_all_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_valid_i && err_ie_i && !wake_ie_i && !soft_rst_i
    |=> irq_flag_o && (buf_data_o == $past(char_data_i)));

  p_overrun_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> $past(char_valid_i));

  p_read_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_read_i && !char_valid_i && !bit_tick_i
    |=> !irq_flag_o && !break_o && !overrun_o && !parity_err_o && !wake_o);

  p_soft_reset_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (buf_data_o == '0) && !irq_flag_o && !break_o && !overrun_o
                   && !parity_err_o && !wake_o);

  p_break_gated_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(break_o) |-> $past(err_ie_i) && $past(bit_tick_i) && !$past(rx_line_i));

  p_break_sticky_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    break_o && !buf_read_i && !soft_rst_i |=> break_o);

endmodule

bind uart_rx_status uart_rx_status_chk #(.DATA_W(DATA_W), .BRK_BITS(BRK_BITS)) i_chk (.*);

// File: tb/test_uart_rx_status.sv
module test_uart_rx_status;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 8;
  localparam int BRK_BITS   = 10;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              char_valid_i = 1'b0;
  logic [DATA_W-1:0] char_data_i = '0;
  logic              char_parity_i = 1'b0;
  logic              char_addr_i = 1'b0;
  logic              frame_err_i = 1'b0;
  logic              rx_line_i = 1'b1;
  logic              bit_tick_i = 1'b0;
  logic              buf_read_i = 1'b0;
  logic              soft_rst_i = 1'b0;
  logic              err_ie_i = 1'b0;
  logic              wake_ie_i = 1'b0;
  logic              parity_odd_i = 1'b0;
  logic [DATA_W-1:0] buf_data_o;
  logic              irq_flag_o, break_o, overrun_o, parity_err_o, wake_o;

  uart_rx_status #(.DATA_W(DATA_W), .BRK_BITS(BRK_BITS)) i_uart_rx_status (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_req  = "R1";
  bit    finished = 0;

  // behavioural reference model
  logic [DATA_W-1:0] m_buf;
  bit m_full, m_irq, m_brk, m_ovr, m_perr, m_wake, m_armed, m_fired;
  int m_cnt;

  always @(posedge clk_i) begin
    bit ev, a_old, full_old, pm, err, acc;
    if (!rst_ni || soft_rst_i) begin
      m_buf = '0; m_full = 0; m_irq = 0; m_brk = 0; m_ovr = 0; m_perr = 0; m_wake = 0;
      m_armed = 0; m_fired = 0; m_cnt = 0;
    end else begin
      ev = 0;
      if (bit_tick_i && rx_line_i) begin
        m_armed = 0; m_fired = 0; m_cnt = 0;
      end else begin
        a_old = m_armed;
        if (bit_tick_i && a_old) begin
          m_cnt++;
          if (m_cnt == BRK_BITS) begin ev = 1; m_fired = 1; m_armed = 0; m_cnt = 0; end
        end
        if (char_valid_i && frame_err_i && !a_old && !m_fired) begin m_armed = 1; m_cnt = 0; end
      end
      full_old = m_full;
      if (buf_read_i) begin
        m_irq = 0; m_brk = 0; m_ovr = 0; m_perr = 0; m_wake = 0; m_full = 0;
      end
      pm  = (^{char_data_i, char_addr_i, char_parity_i}) ^ parity_odd_i;
      err = pm | frame_err_i;
      acc = char_valid_i && (!err || err_ie_i) && (!wake_ie_i || char_addr_i);
      if (acc) begin
        m_buf = char_data_i; m_full = 1; m_irq = 1;
        if (full_old && !buf_read_i) m_ovr = 1;
        if (pm) m_perr = 1;
        if (char_addr_i) m_wake = 1;
      end
      if (ev && err_ie_i) begin m_brk = 1; m_irq = 1; end
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // compare against the model every cycle, away from the active edge
  always @(negedge clk_i) begin
    if (!finished) begin
      chk(cur_req, "buf", 32'(buf_data_o), 32'(m_buf));
      chk(cur_req, "irq", 32'(irq_flag_o), 32'(m_irq));
      chk(cur_req, "brk", 32'(break_o), 32'(m_brk));
      chk(cur_req, "ovr", 32'(overrun_o), 32'(m_ovr));
      chk(cur_req, "perr", 32'(parity_err_o), 32'(m_perr));
      chk(cur_req, "wake", 32'(wake_o), 32'(m_wake));
    end
  end

  task automatic send(logic [7:0] d, logic p, logic a, logic fe);
    @(negedge clk_i);
    char_valid_i = 1; char_data_i = d; char_parity_i = p; char_addr_i = a; frame_err_i = fe;
    @(negedge clk_i);
    char_valid_i = 0; frame_err_i = 0; char_addr_i = 0;
  endtask

  task automatic rd();
    @(negedge clk_i); buf_read_i = 1;
    @(negedge clk_i); buf_read_i = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); bit_tick_i = 1;
      @(negedge clk_i); bit_tick_i = 0;
    end
  endtask

  task automatic summary();
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    cur_req = "R1";
    chk("R1", "buf", 32'(buf_data_o), 0);
    chk("R1", "irq", 32'(irq_flag_o), 0);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R1", "flags", 32'({break_o, overrun_o, parity_err_o, wake_o}), 0);

    cur_req = "R3";
    send(8'hA5, 0, 0, 0);
    chk("R3", "buf", 32'(buf_data_o), 32'hA5);
    chk("R3", "irq", 32'(irq_flag_o), 1);
    cur_req = "R9";
    rd();
    chk("R9", "irq", 32'(irq_flag_o), 0);
    chk("R9", "buf kept", 32'(buf_data_o), 32'hA5);

    cur_req = "R2";
    send(8'h3C, 0, 0, 1);
    chk("R2", "buf frame", 32'(buf_data_o), 32'hA5);
    chk("R2", "irq frame", 32'(irq_flag_o), 0);
    send(8'h01, 0, 0, 0);
    chk("R2", "buf parity", 32'(buf_data_o), 32'hA5);
    send(8'h80, 1, 1, 0);
    chk("R2", "addr bad parity", 32'(buf_data_o), 32'hA5);

    cur_req = "R4";
    wake_ie_i = 1;
    send(8'h11, 0, 0, 0);
    chk("R4", "non-addr", 32'(buf_data_o), 32'hA5);
    chk("R4", "irq", 32'(irq_flag_o), 0);
    send(8'h22, 1, 1, 0);
    chk("R4", "addr", 32'(buf_data_o), 32'h22);
    chk("R7", "wake", 32'(wake_o), 1);
    rd();
    wake_ie_i = 0;

    cur_req = "R5";
    err_ie_i = 1;
    send(8'h07, 0, 0, 0);
    chk("R5", "bad char loads", 32'(buf_data_o), 32'h07);
    chk("R6", "perr", 32'(parity_err_o), 1);
    cur_req = "R8";
    send(8'h08, 1, 0, 1);
    chk("R8", "overrun", 32'(overrun_o), 1);
    chk("R8", "overwrite", 32'(buf_data_o), 32'h08);
    chk("R6", "perr sticky", 32'(parity_err_o), 1);
    rd();

    cur_req = "R6";
    parity_odd_i = 1;
    send(8'h07, 0, 0, 0);
    chk("R6", "odd ok", 32'(parity_err_o), 0);
    send(8'h07, 1, 0, 0);
    chk("R6", "odd bad", 32'(parity_err_o), 1);
    parity_odd_i = 0;

    cur_req = "R9";
    @(negedge clk_i);
    buf_read_i = 1; char_valid_i = 1; char_data_i = 8'h03; char_parity_i = 0;
    @(negedge clk_i);
    buf_read_i = 0; char_valid_i = 0;
    chk("R9", "load wins irq", 32'(irq_flag_o), 1);
    chk("R9", "no overrun", 32'(overrun_o), 0);

    cur_req = "R10";
    @(negedge clk_i); soft_rst_i = 1;
    @(negedge clk_i); soft_rst_i = 0;
    chk("R10", "buf", 32'(buf_data_o), 0);
    chk("R10", "flags", 32'({irq_flag_o, parity_err_o}), 0);

    cur_req = "R11";
    rx_line_i = 0;
    send(8'h00, 0, 0, 1);
    rd();
    ticks(BRK_BITS - 1);
    chk("R11", "no break at 9", 32'(break_o), 0);
    ticks(1);
    chk("R11", "break at 10", 32'(break_o), 1);
    chk("R11", "irq", 32'(irq_flag_o), 1);

    cur_req = "R12";
    send(8'h00, 0, 0, 1);
    chk("R12", "break sticky", 32'(break_o), 1);
    rd();
    ticks(BRK_BITS + 3);
    chk("R12", "once per low", 32'(break_o), 0);

    cur_req = "R11";
    rx_line_i = 1; ticks(1); rx_line_i = 0;
    send(8'h00, 0, 0, 1);
    rd();
    ticks(5);
    rx_line_i = 1; ticks(1); rx_line_i = 0;
    ticks(BRK_BITS - 1);
    chk("R11", "restart", 32'(break_o), 0);
    rx_line_i = 1; ticks(1); rx_line_i = 0;
    err_ie_i = 0;
    send(8'h00, 0, 0, 1);
    ticks(BRK_BITS);
    chk("R11", "gated brk", 32'(break_o), 0);
    chk("R11", "gated irq", 32'(irq_flag_o), 0);
    rx_line_i = 1;
    repeat (3) @(negedge clk_i);
    summary();
  end

endmodule